// File: doc/BRIEF.md
# Grayscale Pixel Pair Packer

This block turns a stored image of 8-bit grayscale pixels into the 4-bit-per-pixel byte stream that a two-row-per-page display controller expects. A start pulse latches a job: the line length, the first and last rows, an orientation flag and a bus-width selector. The block then walks the image through a dual-read line-buffer port and keeps only the upper four bits of every pixel. It folds each pair of pixels into one byte and hands the bytes to a serial transmitter over a valid/ready channel.

In normal orientation a pair is one pixel and the pixel directly beneath it, so one output row covers a whole display page of two lines. In rotated orientation a pair is two neighbouring pixels on the same row. In the 8-bit bus mode the data/command line is held high for the whole job. In the 9-bit bus mode the data marker travels as bit 8 of every word. Command generation and the serial shifter sit outside the block.

Top module: `pkp_top`

## Requirements
- R1: Each output word carries the upper four bits of the first pixel of its pair in bits 3:0 and the upper four bits of the second pixel in bits 7:4.
- R2: In normal orientation (rot = 0) bit 0 of the first row is cleared. Row pairs are walked from there while the pair's top row is not above the last row, with columns 0 to len-1 in each pair. The first pixel sits at row*len+col on port A, and the second at that address plus len on port B.
- R3: In rotated orientation (rot = 1) rows are walked one at a time from the first row to the last row, and columns step by two from 0. The first pixel sits at row*len+col and the second at that address plus 1. The line length must be even.
- R4: With bus_sel = 1 (9-bit bus) every output word has bit 8 set, and out_dc stays low.
- R5: With bus_sel = 0 (8-bit bus) bit 8 of every word is 0. out_dc is high from the cycle after the accepted start until the job ends, so it is already high before the first word. A job emits exactly half as many words as it covers pixels.
- R6: A start with bus_sel = 2 or 3 sets err from the next cycle and produces no word and no busy cycle. The next accepted start clears err.
- R7: With out_ready held high, the words of a job leave on consecutive cycles, one per cycle, with no gap.
- R8: While out_valid is high and out_ready is low, the word and its flags stay unchanged, and no word is lost or repeated.
- R9: out_last is high together with the final word of the job and with no other word.
- R10: A start pulse that arrives while busy is high is ignored, and the running job continues with its own settings.
- R11: After reset out_valid, busy, err and rd_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Job start pulse, taken only while idle |
| cfg_line_len | input | LEN_W | Pixels per stored line |
| cfg_row_first | input | ROW_W | First row of the job |
| cfg_row_last | input | ROW_W | Last row of the job (not below the first row) |
| cfg_rotated | input | 1 | 0: vertical pairs, 1: horizontal pairs |
| cfg_bus_sel | input | 2 | 0: 8-bit bus, 1: 9-bit bus, other values are rejected |
| rd_en | output | 1 | Read strobe for both pixel ports |
| rd_addr_a | output | ADDR_W | Address of the first pixel of a pair |
| rd_addr_b | output | ADDR_W | Address of the second pixel of a pair |
| rd_data_a | input | PIX_W | Port A data, one cycle after rd_en, held while rd_en is low |
| rd_data_b | input | PIX_W | Port B data, one cycle after rd_en, held while rd_en is low |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Transmitter accepts the word |
| out_word | output | 9 | Packed word (bit 8 is the data marker in 9-bit mode) |
| out_dc | output | 1 | Data/command line for the 8-bit bus |
| out_last | output | 1 | Final word of the job |
| busy | output | 1 | A job is in progress |
| err | output | 1 | The last start named an unsupported bus width |

## Verification
Two functions can fall in the same cycle: the hand-off of the current word and the issue of the read for the next word. Holding out_ready high makes them coincide on every cycle. The bench judges this by checking that the words of a job leave in a gapless run whose length equals the word count. A pseudo-random ready pattern makes the transmitter withdraw ready in cycles where a refill would otherwise happen. There the scoreboard checks that each word holds steady while stalled and that the stream arrives in order, with no word lost or repeated.

// File: rtl/pkp_pkg.sv
package pkp_pkg;
    localparam int NIB_W  = 4;
    localparam int WORD_W = 9;

    typedef enum logic [1:0] {
        BUS_8BIT = 2'd0,
        BUS_9BIT = 2'd1
    } bus_sel_e;

    function automatic logic [WORD_W-1:0] pack_word(
        input logic [NIB_W-1:0] first_nib,
        input logic [NIB_W-1:0] second_nib,
        input logic             data_flag
    );
        return {data_flag, second_nib, first_nib};
    endfunction
endpackage

// File: rtl/pkp_addr_gen.sv
module pkp_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 9,
    parameter int ROW_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ROW_W-1:0]  first_i,
    input  logic [ROW_W-1:0]  last_i,
    input  logic              rot_i,
    input  logic              advance,
    output logic              active,
    output logic              rd_en,
    output logic              rd_last,
    output logic [ADDR_W-1:0] addr_a,
    output logic [ADDR_W-1:0] addr_b
);
    localparam logic [LEN_W:0]  LEN_TWO  = (LEN_W+1)'(2);
    localparam logic [ROW_W:0]  ROW_TWO  = (ROW_W+1)'(2);
    localparam logic [ADDR_W-1:0] A_ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_TWO  = ADDR_W'(2);

    typedef struct packed {
        logic              active;
        logic              rot;
        logic [LEN_W-1:0]  len;
        logic [ROW_W-1:0]  last_row;
        logic [ROW_W-1:0]  y;
        logic [LEN_W-1:0]  x;
        logic [ADDR_W-1:0] ptr;
    } walk_t;

    walk_t walk_d, walk_q;
    logic [ROW_W-1:0] y0;
    logic             row_done;

    always_comb begin
        walk_d   = walk_q;
        rd_en    = 1'b0;
        rd_last  = 1'b0;
        row_done = 1'b0;
        y0       = rot_i ? first_i : {first_i[ROW_W-1:1], 1'b0};
        if (!walk_q.active) begin
            if (launch) begin
                walk_d.active   = 1'b1;
                walk_d.rot      = rot_i;
                walk_d.len      = len_i;
                walk_d.last_row = last_i;
                walk_d.x        = '0;
                walk_d.y        = y0;
                walk_d.ptr      = ADDR_W'(y0) * ADDR_W'(len_i);
            end
        end else if (advance) begin
            rd_en = 1'b1;
            if (walk_q.rot) begin
                row_done   = ({1'b0, walk_q.x} + LEN_TWO) >= {1'b0, walk_q.len};
                rd_last    = row_done && (walk_q.y == walk_q.last_row);
                walk_d.ptr = walk_q.ptr + A_TWO;
                if (row_done) begin
                    walk_d.x = '0;
                    walk_d.y = walk_q.y + ROW_W'(1);
                end else begin
                    walk_d.x = walk_q.x + LEN_W'(2);
                end
            end else begin
                row_done = (walk_q.x == walk_q.len - LEN_W'(1));
                rd_last  = row_done && (({1'b0, walk_q.y} + ROW_TWO) > {1'b0, walk_q.last_row});
                if (row_done) begin
                    walk_d.x   = '0;
                    walk_d.y   = walk_q.y + ROW_W'(2);
                    walk_d.ptr = walk_q.ptr + A_ONE + ADDR_W'(walk_q.len);
                end else begin
                    walk_d.x   = walk_q.x + LEN_W'(1);
                    walk_d.ptr = walk_q.ptr + A_ONE;
                end
            end
            if (rd_last) walk_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign active = walk_q.active;
    assign addr_a = walk_q.ptr;
    assign addr_b = walk_q.ptr + (walk_q.rot ? A_ONE : ADDR_W'(walk_q.len));

    // R2
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (walk_q.x < walk_q.len));

    // R3
    rot_even_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && walk_q.rot) |-> !walk_q.x[0]);

    // R10
    launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_q.active && launch) |=> $stable(walk_q.len));
endmodule

// File: rtl/pkp_fmt.sv
module pkp_fmt
    import pkp_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0]  pix_a,
    input  logic [PIX_W-1:0]  pix_b,
    input  logic              nine_bit,
    output logic [WORD_W-1:0] word
);
    logic unused_low_bits;
    assign unused_low_bits = ^{pix_a[PIX_W-NIB_W-1:0], pix_b[PIX_W-NIB_W-1:0]};
    assign word = pack_word(pix_a[PIX_W-1 -: NIB_W], pix_b[PIX_W-1 -: NIB_W], nine_bit);
endmodule

// File: rtl/pkp_top.sv
module pkp_top
    import pkp_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 9,
    parameter int ROW_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  cfg_line_len,
    input  logic [ROW_W-1:0]  cfg_row_first,
    input  logic [ROW_W-1:0]  cfg_row_last,
    input  logic              cfg_rotated,
    input  logic [1:0]        cfg_bus_sel,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr_a,
    output logic [ADDR_W-1:0] rd_addr_b,
    input  logic [PIX_W-1:0]  rd_data_a,
    input  logic [PIX_W-1:0]  rd_data_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic              out_dc,
    output logic              out_last,
    output logic              busy,
    output logic              err
);
    typedef struct packed {
        logic pend;
        logic last;
        logic nine;
        logic err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic gen_active, gen_last, advance, bus_ok, launch;

    assign bus_ok  = (cfg_bus_sel == BUS_8BIT) || (cfg_bus_sel == BUS_9BIT);
    assign busy    = gen_active || ctl_q.pend;
    assign launch  = start && !busy && bus_ok;
    assign advance = !ctl_q.pend || out_ready;

    pkp_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ROW_W(ROW_W)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .len_i   (cfg_line_len),
        .first_i (cfg_row_first),
        .last_i  (cfg_row_last),
        .rot_i   (cfg_rotated),
        .advance (advance),
        .active  (gen_active),
        .rd_en   (rd_en),
        .rd_last (gen_last),
        .addr_a  (rd_addr_a),
        .addr_b  (rd_addr_b)
    );

    pkp_fmt #(.PIX_W(PIX_W)) u_fmt (
        .pix_a    (rd_data_a),
        .pix_b    (rd_data_b),
        .nine_bit (ctl_q.nine),
        .word     (out_word)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (start && !busy) ctl_d.err = !bus_ok;
        if (launch) ctl_d.nine = (cfg_bus_sel == BUS_9BIT);
        if (rd_en) begin
            ctl_d.pend = 1'b1;
            ctl_d.last = gen_last;
        end else if (out_ready) begin
            ctl_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign out_valid = ctl_q.pend;
    assign out_last  = ctl_q.pend && ctl_q.last;
    assign out_dc    = busy && !ctl_q.nine;
    assign err       = ctl_q.err;

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_last)));

    // R8
    no_refill_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !rd_en);

    // R4
    nine_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ctl_q.nine) |-> (out_word[8] && !out_dc));

    // R5
    dc_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !ctl_q.nine) |-> (out_dc && !out_word[8]));

    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !out_valid));

    // R9
    last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(ctl_q.nine));
endmodule

// File: tb/pkp_top_tb.sv
module pkp_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_N      = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [8:0] cfg_line_len = '0;
    logic [7:0] cfg_row_first = '0, cfg_row_last = '0;
    logic       cfg_rotated = 1'b0;
    logic [1:0] cfg_bus_sel = '0;
    logic       rd_en;
    logic [15:0] rd_addr_a, rd_addr_b;
    logic [7:0] rd_data_a = '0, rd_data_b = '0;
    logic       out_valid, out_ready = 1'b1, out_dc, out_last, busy, err;
    logic [8:0] out_word;

    logic [7:0] mem [MEM_N];
    logic [9:0] exp_q [$];
    int checks = 0, fails = 0, got_cnt = 0, cyc = 0;
    int first_hs = -1, last_hs = -1;
    bit stall_on = 1'b0, finished = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    pkp_top u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_en) begin
            rd_data_a <= mem[rd_addr_a[9:0]];
            rd_data_b <= mem[rd_addr_b[9:0]];
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // ready driver: pseudo-random stalls when enabled
    initial forever begin
        @(posedge clk);
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = stall_on ? lfsr[0] : 1'b1;
    end

    // monitor / scoreboard
    initial begin
        bit         held = 1'b0;
        logic [9:0] held_w = '0;
        forever begin
            @(negedge clk);
            if (held && out_valid)
                check({out_last, out_word} == held_w, "R8 stall hold", {out_last, out_word}, held_w);
            held = 1'b0;
            if (out_valid && !out_ready) begin
                held = 1'b1;
                held_w = {out_last, out_word};
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6/R10 unexpected word", out_word, 0);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    check(out_word == e[8:0], "R1/R2/R3 word", out_word, e[8:0]);
                    check(out_last == e[9], "R9 last flag", out_last, e[9]);
                    check(out_dc == !e[8], "R4/R5 dc line", out_dc, !e[8]);
                end
                got_cnt++;
                if (first_hs < 0) first_hs = cyc;
                last_hs = cyc;
            end
        end
    end

    task automatic run_job(input int len, input int rf, input int rl, input bit rot,
                           input bit nine, input bit stall, input bit poke);
        int n;
        exp_q.delete();
        if (!rot) begin
            for (int y = rf & ~1; y <= rl; y += 2)
                for (int x = 0; x < len; x++) begin
                    int a;
                    a = y * len + x;
                    exp_q.push_back({1'b0, nine, mem[a + len][7:4], mem[a][7:4]});
                end
        end else begin
            for (int y = rf; y <= rl; y++)
                for (int x = 0; x < len; x += 2) begin
                    int a;
                    a = y * len + x;
                    exp_q.push_back({1'b0, nine, mem[a + 1][7:4], mem[a][7:4]});
                end
        end
        exp_q[exp_q.size() - 1][9] = 1'b1;
        n = exp_q.size();
        got_cnt = 0; first_hs = -1; last_hs = -1;
        stall_on = stall;
        @(negedge clk);
        cfg_line_len = 9'(len); cfg_row_first = 8'(rf); cfg_row_last = 8'(rl);
        cfg_rotated = rot; cfg_bus_sel = nine ? 2'd1 : 2'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R5 busy after start", busy, 1);
        if (!nine) check(out_dc == 1'b1 && out_valid == 1'b0, "R5 dc before data", out_dc, 1);
        if (poke) begin
            repeat (4) @(negedge clk);
            // R10: start with other settings while busy
            cfg_rotated = ~rot; cfg_bus_sel = nine ? 2'd0 : 2'd1; cfg_line_len = 9'd2;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy || exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(got_cnt == n, "R5/R10 word count", got_cnt, n);
        check(err == 1'b0, "R6 err clear", err, 0);
        if (!stall) check(last_hs - first_hs + 1 == n, "R7 gapless stream", last_hs - first_hs + 1, n);
        stall_on = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MEM_N; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
        repeat (3) @(negedge clk);
        // R11
        check(!out_valid && !busy && !err && !rd_en, "R11 reset state",
              {out_valid, busy, err, rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_job(8, 0, 3, 1'b0, 1'b0, 1'b0, 1'b0);   // R2 R5 R7 normal
        run_job(6, 3, 6, 1'b0, 1'b1, 1'b1, 1'b0);   // R2 odd start, R4, R8
        run_job(10, 1, 4, 1'b1, 1'b0, 1'b0, 1'b0);  // R3 rotated, R7
        run_job(4, 5, 5, 1'b1, 1'b1, 1'b1, 1'b0);   // R3 single row, stalls
        run_job(12, 0, 5, 1'b0, 1'b1, 1'b1, 1'b1);  // R10 start while busy
        // R6: unsupported bus width
        @(negedge clk);
        cfg_bus_sel = 2'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err == 1'b1, "R6 err set", err, 1);
        check(busy == 1'b0, "R6 no busy", busy, 0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check(!out_valid && !busy, "R6 no output", {out_valid, busy}, 0);
        end
        run_job(1, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);   // R9 single word, R6 cleared
        run_job(2, 6, 9, 1'b1, 1'b0, 1'b1, 1'b0);   // R3 narrow rows
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule